// File: doc/BRIEF.md
# Windowed Event Rate Meter

The block reports how many events arrived during a fixed measurement window. A window timer advances once for each cycle in which the time-base tick input is high. When it has seen the programmed number of ticks, the window closes. During the window, a saturating counter records every low-to-high transition of the event input.

A window closes with a single-cycle done condition. In that cycle the count is copied into the rate register, the event counter is cleared and the timer goes back to zero. One cycle later a one-cycle update strobe marks the new value. The rate register then holds that value steady for the whole of the following window, so a consumer can read it at any time.

The timer is a two-state machine. In the state `WIN_RUN` it counts ticks. The transition *expire* goes from `WIN_RUN` to `WIN_DONE` on the tick that completes the window. In the state `WIN_DONE` the window-done condition is asserted. The transition *restart* always returns from `WIN_DONE` to `WIN_RUN` after one cycle.

Top module: `rate_meter`

## Requirements
- R1: The window timer advances only in cycles where `tick` is high. With `win_len` = N (N >= 1), the window closes after N ticks. `rate_upd` rises in the second cycle after the cycle that carried the Nth tick.
- R2: The event counter adds one for each 0-to-1 change of `ev_in`, as sampled on rising clock edges. An input that stays high over many cycles counts once. A high `ev_in` in the first cycle after reset counts as a rise.
- R3: The window-done condition lasts exactly one cycle. In the next cycle `rate_upd` is high for exactly one cycle, and `rate` equals the count of the window that just closed.
- R4: When a window expires, the event counter is cleared and the timer restarts from zero. A tick that arrives in the `WIN_DONE` cycle is not counted, so the next window again needs N ticks.
- R5: `rate` changes only together with `rate_upd`. Between two strobes it keeps the value of the last closed window.
- R6: An event rise in the `WIN_DONE` cycle is counted in the new window and is not lost.
- R7: The event counter saturates at 2^CNT_W - 1 instead of wrapping, and the reported rate is then that value.
- R8: `rst` is synchronous and active high. It clears the timer, the counter and `rate` to 0. `rate_upd` stays low during reset and in the first cycle after it.
- R9: `win_len` = 0 behaves exactly like `win_len` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick, one cycle per time unit |
| ev_in | input | 1 | Event input, counted on its rising edges |
| win_len | input | TMR_W | Window length in ticks |
| rate | output | CNT_W | Event count of the last closed window |
| rate_upd | output | 1 | One-cycle strobe when `rate` is refreshed |

## Verification
The assertions assume that `win_len` changes only while the timer is at zero. The bench therefore changes `win_len` only in the cycle after a window has closed. They also assume that a reset is held for at least one clock edge. Every scenario starts with `ev_in` low, so the first pulse of each window is a genuine rise. Ticks in the `WIN_DONE` cycle are generated only on purpose, to exercise R4.

// File: rtl/rate_meter_pkg.sv
package rate_meter_pkg;

    // Window timer states
    typedef enum logic [0:0] {
        WIN_RUN  = 1'b0,   // counting time-base ticks
        WIN_DONE = 1'b1    // one-cycle window-closed state
    } win_state_t;

endpackage

// File: rtl/rate_edge.sv
module rate_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/rate_window_fsm.sv
module rate_window_fsm
    import rate_meter_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [TMR_W-1:0] win_len,
    output logic             win_done
);
    localparam int EXT_W = TMR_W + 1;

    win_state_t       st_q, st_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic [EXT_W-1:0] tmr_inc;
    logic             last_tick;

    assign tmr_inc   = {1'b0, tmr_q} + {{TMR_W{1'b0}}, 1'b1};
    assign last_tick = tick && (tmr_inc >= {1'b0, win_len});

    // next state and timer value
    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        unique case (st_q)
            WIN_RUN: begin
                if (last_tick) begin            // transition: expire
                    st_d  = WIN_DONE;
                    tmr_d = '0;
                end else if (tick) begin
                    tmr_d = tmr_inc[TMR_W-1:0];
                end
            end
            WIN_DONE: begin                     // transition: restart
                st_d  = WIN_RUN;
                tmr_d = '0;
            end
            default: begin
                st_d  = WIN_RUN;
                tmr_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WIN_RUN;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
        end
    end

    // outputs
    always_comb begin
        win_done = 1'b0;
        unique case (st_q)
            WIN_RUN:  win_done = 1'b0;
            WIN_DONE: win_done = 1'b1;
            default:  win_done = 1'b0;
        endcase
    end
endmodule

// File: rtl/rate_event_cnt.sv
module rate_event_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= rise ? CNT_ONE : '0;     // rise at expiry opens the new window
        end else if (rise && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/rate_meter.sv
module rate_meter #(
    parameter int TMR_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ev_in,
    input  logic [TMR_W-1:0] win_len,
    output logic [CNT_W-1:0] rate,
    output logic             rate_upd
);
    logic             ev_rise;
    logic             win_done;
    logic [CNT_W-1:0] ev_cnt;

    rate_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (ev_in),
        .rise   (ev_rise)
    );

    rate_window_fsm #(.TMR_W(TMR_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .win_len  (win_len),
        .win_done (win_done)
    );

    rate_event_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .rise    (ev_rise),
        .restart (win_done),
        .cnt     (ev_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rate     <= '0;
            rate_upd <= 1'b0;
        end else begin
            rate_upd <= win_done;
            if (win_done) rate <= ev_cnt;
        end
    end
endmodule

// File: rtl/rate_meter_chk.sv
module rate_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             win_done,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rate,
    input logic             rate_upd
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) win_done |=> !win_done); // R3
    AST_UPD_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst) win_done |=> rate_upd); // R3
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst) rate_upd |=> !rate_upd); // R3
    AST_RATE_LATCH: assert property (@(posedge clk) disable iff (rst) win_done |=> (rate == $past(cnt))); // R3
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst) win_done |=> (cnt <= 1)); // R4
    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst) !rate_upd |-> $stable(rate)); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst) !$past(win_done) |-> (cnt >= $past(cnt))); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (!rate_upd && rate == 0)); // R8
endmodule

bind rate_meter rate_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .win_done (win_done),
    .cnt      (ev_cnt),
    .rate     (rate),
    .rate_upd (rate_upd)
);

// File: tb/test_rate_meter.sv
`timescale 1ns/1ps
module test_rate_meter;
    localparam int TW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          ev_in = 1'b0;
    logic [TW-1:0] win_len = 8'd4;
    logic [CW-1:0] rate;
    logic          rate_upd;

    int n_chk  = 0;
    int n_fail = 0;
    int prev   = 0;

    always #2.5 clk = ~clk;

    rate_meter #(.TMR_W(TW), .CNT_W(CW)) i_rate_meter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ev_in    (ev_in),
        .win_len  (win_len),
        .rate     (rate),
        .rate_upd (rate_upd)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: drive at falling edge, sample 1 ns after rising edge
    task automatic step(input bit t, input bit e);
        @(negedge clk);
        tick  = t;
        ev_in = e;
        @(posedge clk);
        #1;
    endtask

    // p ticks spaced by gap idle cycles, k pulses of w cycles each,
    // then the closing cycle (busy: tick and event rise in it)
    task automatic run_window(input int p, input int gap, input int k, input int w,
                              input bit busy, input int exp, input string tag);
        int n;
        n = p * (gap + 1);
        for (int i = 0; i < n; i++) begin
            step(i % (gap + 1) == gap, (i < k * (w + 1)) && (i % (w + 1) != 0));
            chk_eq("R5 hold", int'(rate), prev);
            chk_eq("R1 no early strobe", int'(rate_upd), 0);
        end
        step(busy, busy);
        chk_eq("R1 R4 strobe timing", int'(rate_upd), 1);
        chk_eq(tag, int'(rate), exp);
        prev = exp;
    endtask

    task automatic test_reset_start();
        for (int i = 0; i < 3; i++) begin
            step(i[0], ~i[0]);
            chk_eq("R8 rate in reset", int'(rate), 0);
            chk_eq("R8 strobe in reset", int'(rate_upd), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        ev_in = 1'b0;
        tick = 1'b0;
    endtask

    task automatic test_basic();
        win_len = 8'd4;
        run_window(4, 0, 2, 1, 1'b0, 2, "R3 two events");
        run_window(4, 1, 1, 5, 1'b0, 1, "R2 held input counts once");
    endtask

    task automatic test_edge_at_expiry();
        win_len = 8'd3;
        run_window(3, 0, 1, 1, 1'b1, 1, "R2 one event");
        run_window(3, 0, 0, 1, 1'b0, 1, "R6 rise at expiry kept");
        run_window(3, 0, 0, 1, 1'b0, 0, "R4 empty window");
    endtask

    task automatic test_saturation();
        win_len = 8'd45;
        run_window(45, 0, 20, 1, 1'b0, 15, "R7 saturate");
    endtask

    task automatic test_short_windows();
        win_len = 8'd0;
        run_window(1, 2, 1, 1, 1'b0, 1, "R9 length zero");
        win_len = 8'd1;
        run_window(1, 2, 0, 1, 1'b0, 0, "R9 length one");
    endtask

    task automatic test_mid_reset();
        win_len = 8'd4;
        run_window(4, 0, 2, 1, 1'b0, 2, "R3 before reset");
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            step(1'b1, 1'b0);
            chk_eq("R8 rate cleared", int'(rate), 0);
            chk_eq("R8 no strobe", int'(rate_upd), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        tick = 1'b0;
        @(posedge clk);
        #1;
        chk_eq("R8 quiet after reset", int'(rate_upd), 0);
        prev = 0;
        run_window(4, 0, 1, 1, 1'b0, 1, "R3 after reset");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        test_reset_start();
        test_basic();
        test_edge_at_expiry();
        test_saturation();
        test_short_windows();
        test_mid_reset();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule